// File: doc/BRIEF.md
# External Interrupt Sense Unit

This block watches a small set of external interrupt pins and turns each one into an interrupt request. Every pin has its own two-bit sense field. The field picks one of four modes: a low level, a falling edge, a rising edge, or no trigger at all. Each pin first goes through a multi-stage synchronizer. After that, a change is detected by comparing the synchronized value with the value it had one cycle earlier.

The two kinds of trigger are handled differently:
- **Level mode:** the request is never stored. It follows the synchronized pin and disappears as soon as the pin returns high.
- **Edge modes:** a matching edge sets a sticky flag. The flag stays set until a clear pulse arrives. That pulse may come from software or from the interrupt acknowledge.

A cleared flag does not set again while the pin holds its new level. Only a fresh edge sets it. If a clear and a new edge land in the same cycle, the edge wins.

Each request is gated by a per-pin enable. The flag itself records edges whether the pin is enabled or not.

The block samples the pad input even while the pin is driven as an output. Software can therefore raise an interrupt by driving the pin.

Each pin has a two-state flag machine:
- **States:** `FLAG_IDLE` (no edge recorded) and `FLAG_HELD` (edge recorded).
- **Transitions:**
  - Capture moves `FLAG_IDLE` to `FLAG_HELD` on a matching edge.
  - Release moves `FLAG_HELD` to `FLAG_IDLE` on a clear with no matching edge in that cycle.
  - Hold keeps `FLAG_HELD` in every other case, including clear together with edge.
  - Wait keeps `FLAG_IDLE` while no matching edge is seen.

Top module: `ext_irq_sense`

## Requirements
- R1: A change on a pin reaches the level request after SYNC_STAGES rising clock edges. An edge flag sets one edge after that. Before those edges the outputs keep their previous value.
- R2: Sense field value 00 selects low level. The field for pin i sits at `sense_cfg[2i+1:2i]`. In this mode an enabled pin's request is 1 for as long as the synchronized pin is 0.
- R3: In low-level mode nothing is latched. The request returns to 0 once the synchronized pin is 1, with no clear applied, and the edge flag does not set.
- R4: Sense field value 01 triggers nothing. Neither the flag nor the request of that pin becomes 1, whatever the pin does.
- R5: Sense field value 10 selects falling edge. A 1-to-0 transition of the synchronized pin sets the flag, which then stays set until cleared. A 0-to-1 transition does not set it.
- R6: Sense field value 11 selects rising edge. A 0-to-1 transition sets the flag. A 1-to-0 transition does not set it.
- R7: A one-cycle pulse on `flag_clr[i]` with no matching edge in that cycle clears flag i. The flag then stays 0 while the pin holds its level, until a new matching edge.
- R8: When a clear and a matching edge fall in the same cycle, the flag is 1 afterwards.
- R9: `irq_req[i]` is `irq_en[i]` AND (level condition OR flag i). The flag records edges while the enable is 0, so a later enable raises the request immediately.
- R10: Pins are independent. Stimulus, sense field, enable or clear on one pin leaves the other pin's flag and request unchanged.
- R11: After reset all flags and requests are 0. The synchronizer and previous-value registers reset to 1 (pin idle high).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | NUM_PINS | Pad inputs, sampled also while the pin is driven |
| sense_cfg | input | 2*NUM_PINS | Sense field per pin, pin i at [2i+1:2i] |
| irq_en | input | NUM_PINS | Request enable per pin |
| flag_clr | input | NUM_PINS | One-cycle flag clear per pin (software or acknowledge) |
| irq_req | output | NUM_PINS | Interrupt request per pin |
| edge_flag | output | NUM_PINS | Sticky edge flag per pin |

## Verification
The bench builds the block with its defaults, NUM_PINS = 2 and SYNC_STAGES = 2. Two pins are enough to check that the pins stay independent and to drive edges on both pins in the same cycle. Two stages give a short, exactly countable latency. This lets the bench time a clear pulse so that it lands in the very cycle an edge is detected, and so reach the clear-versus-edge race.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;

    localparam int SENSE_W = 2;

    typedef enum logic [SENSE_W-1:0] {
        SENSE_LOW  = 2'b00,
        SENSE_OFF  = 2'b01,
        SENSE_FALL = 2'b10,
        SENSE_RISE = 2'b11
    } sense_mode_e;

    typedef enum logic {
        FLAG_IDLE = 1'b0,
        FLAG_HELD = 1'b1
    } flag_state_e;

endpackage

// File: rtl/ext_irq_sync.sv
module ext_irq_sync #(
    parameter int   STAGES    = 2,
    parameter logic RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);

    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= RESET_VAL;
                else        chain_q <= d_i;
            end
        end else begin : g_multi
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= {STAGES{RESET_VAL}};
                else        chain_q <= {chain_q[STAGES-2:0], d_i};
            end
        end
    endgenerate

    assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/ext_irq_channel.sv
module ext_irq_channel
    import ext_irq_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               pin_i,
    input  logic [SENSE_W-1:0] sense_i,
    input  logic               en_i,
    input  logic               clr_i,
    output logic               sync_o,
    output logic               flag_o,
    output logic               irq_o
);

    sense_mode_e mode;
    flag_state_e state_q, state_d;
    logic        cur_lvl;
    logic        prev_lvl_q;
    logic        fell, rose;
    logic        edge_hit;
    logic        level_act;

    assign mode = sense_mode_e'(sense_i);

    ext_irq_sync #(
        .STAGES    (SYNC_STAGES),
        .RESET_VAL (1'b1)
    ) sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (pin_i),
        .q_o   (cur_lvl)
    );

    // previous synchronized level, for edge comparison
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_lvl_q <= 1'b1;
        else        prev_lvl_q <= cur_lvl;
    end

    assign fell = prev_lvl_q & ~cur_lvl;
    assign rose = ~prev_lvl_q & cur_lvl;

    always_comb begin
        edge_hit  = 1'b0;
        level_act = 1'b0;
        unique case (mode)
            SENSE_LOW:  level_act = ~cur_lvl;
            SENSE_OFF:  edge_hit  = 1'b0;
            SENSE_FALL: edge_hit  = fell;
            SENSE_RISE: edge_hit  = rose;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FLAG_IDLE;
        else        state_q <= state_d;
    end

    // next state: capture / wait / hold / release; edge beats clear
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLAG_IDLE: if (edge_hit)            state_d = FLAG_HELD;
            FLAG_HELD: if (clr_i && !edge_hit)  state_d = FLAG_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        flag_o = (state_q == FLAG_HELD);
        irq_o  = en_i & (level_act | flag_o);
        sync_o = cur_lvl;
    end

endmodule

// File: rtl/ext_irq_sense.sv
module ext_irq_sense
    import ext_irq_pkg::*;
#(
    parameter int NUM_PINS    = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_PINS-1:0]         pin_in,
    input  logic [SENSE_W*NUM_PINS-1:0] sense_cfg,
    input  logic [NUM_PINS-1:0]         irq_en,
    input  logic [NUM_PINS-1:0]         flag_clr,
    output logic [NUM_PINS-1:0]         irq_req,
    output logic [NUM_PINS-1:0]         edge_flag
);

    logic [NUM_PINS-1:0] pin_sync;

    generate
        for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
            ext_irq_channel #(
                .SYNC_STAGES (SYNC_STAGES)
            ) chan_i (
                .clk     (clk),
                .rst_n   (rst_n),
                .pin_i   (pin_in[i]),
                .sense_i (sense_cfg[SENSE_W*i +: SENSE_W]),
                .en_i    (irq_en[i]),
                .clr_i   (flag_clr[i]),
                .sync_o  (pin_sync[i]),
                .flag_o  (edge_flag[i]),
                .irq_o   (irq_req[i])
            );
        end
    endgenerate

endmodule

// File: rtl/ext_irq_sense_chk.sv
module ext_irq_sense_chk #(
    parameter int NUM_PINS = 2
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [2*NUM_PINS-1:0] sense_cfg,
    input logic [NUM_PINS-1:0]   irq_en,
    input logic [NUM_PINS-1:0]   flag_clr,
    input logic [NUM_PINS-1:0]   pin_sync,
    input logic [NUM_PINS-1:0]   irq_req,
    input logic [NUM_PINS-1:0]   edge_flag
);

    generate
        for (genvar i = 0; i < NUM_PINS; i++) begin : g_chk
            p_level_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
                (irq_en[i] && sense_cfg[2*i +: 2] == 2'b00 && !pin_sync[i]) |-> irq_req[i]);

            p_level_gone_r3: assert property (@(posedge clk) disable iff (!rst_n)
                (sense_cfg[2*i +: 2] == 2'b00 && pin_sync[i] && !edge_flag[i]) |-> !irq_req[i]);

            p_off_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
                (sense_cfg[2*i +: 2] == 2'b01 && !edge_flag[i]) |=> !edge_flag[i]);

            p_fall_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
                (sense_cfg[2*i +: 2] == 2'b10 && $fell(pin_sync[i])) |=> edge_flag[i]);

            p_rise_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
                (sense_cfg[2*i +: 2] == 2'b11 && $rose(pin_sync[i])) |=> edge_flag[i]);

            p_rose_needs_edge_mode_r5: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(edge_flag[i]) |-> $past(sense_cfg[2*i+1]));

            p_clear_quiet_pin_r7: assert property (@(posedge clk) disable iff (!rst_n)
                (flag_clr[i] && $stable(pin_sync[i])) |=> !edge_flag[i]);

            p_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
                (edge_flag[i] && !flag_clr[i]) |=> edge_flag[i]);

            p_enable_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
                !irq_en[i] |-> !irq_req[i]);

            p_flag_drives_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
                (irq_en[i] && edge_flag[i]) |-> irq_req[i]);
        end
    endgenerate

endmodule

bind ext_irq_sense ext_irq_sense_chk #(
    .NUM_PINS (NUM_PINS)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .sense_cfg (sense_cfg),
    .irq_en    (irq_en),
    .flag_clr  (flag_clr),
    .pin_sync  (pin_sync),
    .irq_req   (irq_req),
    .edge_flag (edge_flag)
);

// File: tb/ext_irq_sense_tb_top.sv
`timescale 1ns/1ps
module ext_irq_sense_tb_top;

    localparam int NP = 2;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [NP-1:0] pin;
    logic [2*NP-1:0] cfg;
    logic [NP-1:0] en;
    logic [NP-1:0] clr;
    wire  [NP-1:0] irq;
    wire  [NP-1:0] flag;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    ext_irq_sense #(.NUM_PINS(NP), .SYNC_STAGES(2)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_in    (pin),
        .sense_cfg (cfg),
        .irq_en    (en),
        .flag_clr  (clr),
        .irq_req   (irq),
        .edge_flag (flag)
    );

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0b expected %0b", req, what, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_clr(input int p);
        clr[p] = 1'b1;
        wait_n(1);
        clr[p] = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0; pin = '1; cfg = '0; en = '0; clr = '0;
        wait_n(3);
        rst_n = 1'b1;
        wait_n(1);
        chk("R11", "irq0 after reset",  irq[0],  1'b0);
        chk("R11", "irq1 after reset",  irq[1],  1'b0);
        chk("R11", "flag0 after reset", flag[0], 1'b0);
        chk("R11", "flag1 after reset", flag[1], 1'b0);
    endtask

    task automatic t_level();
        cfg = 4'b01_00; en = 2'b11;
        wait_n(1);
        pin[0] = 1'b0;
        wait_n(1);
        chk("R1", "irq0 one edge after low", irq[0], 1'b0);
        wait_n(1);
        chk("R2", "irq0 two edges after low", irq[0], 1'b1);
        wait_n(5);
        chk("R2", "irq0 held low", irq[0], 1'b1);
        chk("R3", "flag0 not latched in level", flag[0], 1'b0);
        chk("R10", "irq1 untouched", irq[1], 1'b0);
        pin[0] = 1'b1;
        wait_n(2);
        chk("R3", "irq0 after pin high", irq[0], 1'b0);
    endtask

    task automatic t_reserved();
        cfg[1:0] = 2'b01;
        pin[0] = 1'b0;
        wait_n(4);
        chk("R4", "irq0 low in off mode",  irq[0],  1'b0);
        chk("R4", "flag0 low in off mode", flag[0], 1'b0);
        pin[0] = 1'b1;
        wait_n(4);
        chk("R4", "flag0 after rise in off mode", flag[0], 1'b0);
    endtask

    task automatic t_falling();
        cfg[1:0] = 2'b10;
        pin[0] = 1'b0;
        wait_n(2);
        chk("R1", "flag0 before edge latency", flag[0], 1'b0);
        wait_n(1);
        chk("R5", "flag0 after fall", flag[0], 1'b1);
        chk("R5", "irq0 after fall",  irq[0],  1'b1);
        wait_n(5);
        chk("R5", "flag0 sticky", flag[0], 1'b1);
        pulse_clr(0);
        chk("R7", "flag0 after clear", flag[0], 1'b0);
        wait_n(6);
        chk("R7", "flag0 stays clear, pin still low", flag[0], 1'b0);
        pin[0] = 1'b1;
        wait_n(4);
        chk("R5", "flag0 rise ignored in fall mode", flag[0], 1'b0);
    endtask

    task automatic t_rising();
        cfg[1:0] = 2'b11;
        pin[0] = 1'b0;
        wait_n(4);
        chk("R6", "flag0 fall ignored in rise mode", flag[0], 1'b0);
        pin[0] = 1'b1;
        wait_n(3);
        chk("R6", "flag0 after rise", flag[0], 1'b1);
        chk("R6", "irq0 after rise",  irq[0],  1'b1);
    endtask

    task automatic t_race();
        pin[0] = 1'b0;
        wait_n(4);
        pin[0] = 1'b1;
        wait_n(2);
        clr[0] = 1'b1;
        wait_n(1);
        clr[0] = 1'b0;
        chk("R8", "flag0 clear meets edge", flag[0], 1'b1);
        pulse_clr(0);
        chk("R7", "flag0 plain clear", flag[0], 1'b0);
    endtask

    task automatic t_enable();
        en = 2'b01;
        cfg[3:2] = 2'b10;
        pin[1] = 1'b0;
        wait_n(3);
        chk("R9", "flag1 set while disabled", flag[1], 1'b1);
        chk("R9", "irq1 gated by enable",     irq[1],  1'b0);
        chk("R10", "flag0 untouched by pin1", flag[0], 1'b0);
        chk("R10", "irq0 untouched by pin1",  irq[0],  1'b0);
        en[1] = 1'b1;
        wait_n(1);
        chk("R9", "irq1 after enable", irq[1], 1'b1);
        pulse_clr(1);
        chk("R7", "flag1 after clear", flag[1], 1'b0);
        cfg = 4'b11_11;
        pin[0] = 1'b0;
        wait_n(4);
        pin = 2'b11;
        wait_n(3);
        chk("R10", "flag0 joint rise", flag[0], 1'b1);
        chk("R10", "flag1 joint rise", flag[1], 1'b1);
        pulse_clr(0);
        chk("R10", "flag1 kept when pin0 cleared", flag[1], 1'b1);
        chk("R10", "flag0 cleared",                flag[0], 1'b0);
    endtask

    initial begin
        t_reset();
        t_level();
        t_reserved();
        t_falling();
        t_rising();
        t_race();
        t_enable();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #800000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule